// File: doc/BRIEF.md
# Serial debug link activation controller

This block decides when a two-wire synchronous debug/programming link is live. The link has one clock line, driven by the external programmer, and one data line. Both are sampled asynchronously into the system clock domain. Software or a pad controller asks for activation by pulsing a request, which also switches off the reset function of the pin that is shared with the link clock. From that moment the programmer has a bounded number of system cycles to produce its first link-clock rising edge. After that it must deliver an uninterrupted run of rising edges with the data line held high.

Once the run is complete the link-enabled flag rises. An inactivity watchdog tears the link down whenever the link clock stops toggling for longer than a parameterised number of system cycles. This holds during the handshake and after it. When the link drops, the shared pin gets its reset function back, unless a static configuration input keeps that function disabled for good. Both the deadline and the inactivity limit are plain system-cycle counts, so the integrator derives them from the system clock frequency.

Top module: `dla_link_activator`

## Requirements
- R1: After reset `link_en` is 0 and `rstfn_en` equals the inverse of `perm_rst_off`.
- R2: A one-cycle `act_req` while idle clears `rstfn_en` from the next cycle on; `link_en` stays 0.
- R3: If no link-clock rising edge is seen within `DEADLINE_CYC` system cycles of the request, the block returns to idle and `rstfn_en` returns to the inverse of `perm_rst_off`.
- R4: `EDGES` (default 16) consecutive link-clock rising edges, each sampled with the data line at 1, set `link_en` to 1. After only `EDGES-1` such edges, `link_en` is still 0. Only rising edges count, and each takes effect three system cycles after it appears at the pins.
- R5: A rising edge sampled with the data line at 0 during the handshake clears the edge count but keeps the handshake armed. A full run of `EDGES` high edges is then needed again.
- R6: When no link-clock rising edge arrives for more than `IDLE_CYC` system cycles, the block drops to idle. This applies both during the handshake and while `link_en` is 1, and `link_en` goes to 0. Any rising edge restarts this window.
- R7: While `perm_rst_off` is 1, `rstfn_en` stays 0 in every state, including after a deadline or inactivity timeout.
- R8: `link_en` and `rstfn_en` are never 1 at the same time.
- R9: `act_req` has no effect while the block is not idle: an active link stays active.
- R10: A timeout during the handshake discards all edges counted so far. A later request needs the full run of `EDGES` high edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Activation request pulse; disables the pin reset function |
| perm_rst_off | input | 1 | Static: reset function of the shared pin permanently disabled |
| lnk_clk_in | input | 1 | Raw link clock line |
| lnk_dat_in | input | 1 | Raw link data line |
| link_en | output | 1 | Link active and ready for instructions |
| rstfn_en | output | 1 | Reset function of the shared pin enabled |

## Verification
A state register stuck in the wrong place shows at the ports within one cycle, because both outputs decode it directly. For example, a handshake that never left idle keeps `rstfn_en` high right after the request. A miscounting edge counter only shows when the last handshake edge arrives: `link_en` rises one edge early, one edge late, or not at all. Each edge reaches the outputs three system cycles after it appears at the pins. A timer with a wrong load value shows as a drop to idle too early or too late, so the bench samples once well inside and once well outside each window.

// File: rtl/dla_pkg.sv
package dla_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ARMED  = 2'd1,
      ST_COUNT  = 2'd2,
      ST_ACTIVE = 2'd3
   } dla_state_e;
endpackage

// File: rtl/dla_sync_edge.sv
module dla_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_raw,
   input  logic dat_raw,
   output logic rise,
   output logic dat_s
);
   logic [STAGES-1:0] clk_sh;
   logic [STAGES-1:0] dat_sh;
   logic              clk_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dla_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sh   <= '0;
         dat_sh   <= '0;
         clk_prev <= 1'b0;
      end else begin
         clk_sh   <= {clk_sh[STAGES-2:0], clk_raw};
         dat_sh   <= {dat_sh[STAGES-2:0], dat_raw};
         clk_prev <= clk_sh[STAGES-1];
      end
   end

   assign rise  = clk_sh[STAGES-1] & ~clk_prev;
   assign dat_s = dat_sh[STAGES-1];
endmodule

// File: rtl/dla_timer.sv
module dla_timer #(
   parameter int LOAD = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int W = $clog2(LOAD + 1);

   logic [W-1:0] cnt;

   generate
      if (LOAD < 1) begin : g_bad_load
         $error("dla_timer: LOAD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= W'(LOAD);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/dla_link_activator.sv
module dla_link_activator
   import dla_pkg::*;
#(
   parameter int EDGES        = 16,
   parameter int DEADLINE_CYC = 64,
   parameter int IDLE_CYC     = 200,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_req,
   input  logic perm_rst_off,
   input  logic lnk_clk_in,
   input  logic lnk_dat_in,
   output logic link_en,
   output logic rstfn_en
);
   localparam int CW = $clog2(EDGES + 1);

   generate
      if (EDGES < 1) begin : g_bad_edges
         $error("dla_link_activator: EDGES must be at least 1");
      end
   endgenerate

   dla_state_e    st, st_n;
   logic [CW-1:0] ecnt, ecnt_n, ecnt_base, ecnt_inc;
   logic          lnk_rise, dat_s;
   logic          dl_load, dl_exp, ia_load, ia_exp;

   dla_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_raw (lnk_clk_in),
      .dat_raw (lnk_dat_in),
      .rise    (lnk_rise),
      .dat_s   (dat_s)
   );

   dla_timer #(.LOAD(DEADLINE_CYC)) i_deadline (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (dl_load),
      .expired (dl_exp)
   );

   dla_timer #(.LOAD(IDLE_CYC)) i_inactivity (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ia_load),
      .expired (ia_exp)
   );

   assign ecnt_base = (st == ST_ARMED) ? '0 : ecnt;
   assign ecnt_inc  = ecnt_base + 1'b1;

   always_comb begin
      st_n    = st;
      ecnt_n  = ecnt;
      dl_load = 1'b0;
      ia_load = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (act_req) begin
               st_n    = ST_ARMED;
               dl_load = 1'b1;
            end
         end
         ST_ARMED, ST_COUNT: begin
            if (lnk_rise) begin
               ia_load = 1'b1;
               if (!dat_s) begin
                  ecnt_n = '0;
                  st_n   = ST_COUNT;
               end else if (ecnt_inc == CW'(EDGES)) begin
                  ecnt_n = '0;
                  st_n   = ST_ACTIVE;
               end else begin
                  ecnt_n = ecnt_inc;
                  st_n   = ST_COUNT;
               end
            end else if ((st == ST_ARMED) ? dl_exp : ia_exp) begin
               st_n = ST_IDLE;
            end
         end
         ST_ACTIVE: begin
            if (lnk_rise)    ia_load = 1'b1;
            else if (ia_exp) st_n    = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         ecnt <= '0;
      end else begin
         st   <= st_n;
         ecnt <= ecnt_n;
      end
   end

   assign link_en  = (st == ST_ACTIVE);
   assign rstfn_en = (st == ST_IDLE) & ~perm_rst_off;
endmodule

// File: rtl/dla_link_chk.sv
module dla_link_chk
   import dla_pkg::*;
#(
   parameter int DEADLINE_CYC = 64,
   parameter int IDLE_CYC     = 200
) (
   input logic       clk,
   input logic       rst_n,
   input logic       act_req,
   input logic       perm_rst_off,
   input logic       link_en,
   input logic       rstfn_en,
   input logic       lnk_rise,
   input dla_state_e st
);
   localparam int AW = $clog2(DEADLINE_CYC + 2);
   localparam int IW = $clog2(IDLE_CYC + 2);

   logic [AW-1:0] arm_cnt;
   logic [IW-1:0] since_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_cnt    <= '0;
         since_rise <= '0;
      end else begin
         if (st != ST_ARMED)                      arm_cnt <= '0;
         else if (arm_cnt != AW'(DEADLINE_CYC + 1)) arm_cnt <= arm_cnt + 1'b1;
         if (lnk_rise)                              since_rise <= '0;
         else if (since_rise != IW'(IDLE_CYC + 1))  since_rise <= since_rise + 1'b1;
      end
   end

   p_req_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rstfn_en && act_req) |=> !rstfn_en);

   p_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ARMED) |-> (arm_cnt <= AW'(DEADLINE_CYC)));

   p_enable_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_en) |-> $past(lnk_rise));

   p_inactivity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      link_en |-> (since_rise <= IW'(IDLE_CYC)));

   p_no_drop_on_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_en) |-> !$past(lnk_rise));

   p_perm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      perm_rst_off |-> !rstfn_en);

   p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_en && rstfn_en));
endmodule

bind dla_link_activator dla_link_chk #(
   .DEADLINE_CYC (DEADLINE_CYC),
   .IDLE_CYC     (IDLE_CYC)
) i_dla_link_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .act_req      (act_req),
   .perm_rst_off (perm_rst_off),
   .link_en      (link_en),
   .rstfn_en     (rstfn_en),
   .lnk_rise     (lnk_rise),
   .st           (st)
);

// File: tb/test_dla_link_activator.sv
module test_dla_link_activator;
   localparam int CLK_PERIOD = 10;
   localparam int EDGES      = 16;
   localparam int DL         = 64;
   localparam int IDL        = 200;
   localparam int HP         = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic act_req = 1'b0;
   logic perm_rst_off = 1'b0;
   logic lnk_clk_in = 1'b0;
   logic lnk_dat_in = 1'b0;
   logic link_en, rstfn_en;

   int checks = 0;
   int failures = 0;

   typedef struct {
      bit    lnk;
      bit    rst;
      string tag;
   } exp_t;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dla_link_activator #(
      .EDGES(EDGES), .DEADLINE_CYC(DL), .IDLE_CYC(IDL), .SYNC_STAGES(2)
   ) i_dla_link_activator (
      .clk(clk), .rst_n(rst_n), .act_req(act_req), .perm_rst_off(perm_rst_off),
      .lnk_clk_in(lnk_clk_in), .lnk_dat_in(lnk_dat_in),
      .link_en(link_en), .rstfn_en(rstfn_en)
   );

   // monitor: pops expected items and compares them at a falling edge
   initial begin
      forever begin
         exp_t e;
         wait (q.size() > 0);
         @(negedge clk);
         e = q.pop_front();
         checks++;
         if (link_en !== e.lnk || rstfn_en !== e.rst) begin
            failures++;
            $display("FAIL %s: link_en=%b rstfn_en=%b expected link_en=%b rstfn_en=%b",
                     e.tag, link_en, rstfn_en, e.lnk, e.rst);
         end
         checks++;
         if (link_en === 1'b1 && rstfn_en === 1'b1) begin
            failures++;
            $display("FAIL R8 (%s): link_en=1 rstfn_en=1 expected not both 1", e.tag);
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_io(input bit l, input bit r, input string tag);
      exp_t e;
      e.lnk = l; e.rst = r; e.tag = tag;
      q.push_back(e);
      wait (q.size() == 0);
      @(negedge clk);
   endtask

   task automatic send_req();
      act_req = 1'b1;
      cyc(1);
      act_req = 1'b0;
   endtask

   task automatic pulse(input bit d);
      lnk_dat_in = d;
      cyc(HP);
      lnk_clk_in = 1'b1;
      cyc(HP);
      lnk_clk_in = 1'b0;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) pulse(1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      expect_io(1'b0, 1'b1, "R1 reset state");

      // R2 request, then R3 deadline expiry
      send_req();
      expect_io(1'b0, 1'b0, "R2 request clears reset function");
      cyc(DL - 12);
      expect_io(1'b0, 1'b0, "R3 still armed inside deadline");
      cyc(20);
      expect_io(1'b0, 1'b1, "R3 deadline expired, back to idle");

      // R4 full handshake with boundary at EDGES-1
      send_req();
      pulses(EDGES - 1);
      cyc(2);
      expect_io(1'b0, 1'b0, "R4 one edge short");
      pulse(1'b1);
      cyc(2);
      expect_io(1'b1, 1'b0, "R4 link enabled after full run");

      // R9 request ignored while active
      send_req();
      cyc(3);
      expect_io(1'b1, 1'b0, "R9 request ignored while active");

      // R6 inactivity while active
      pulse(1'b1);
      cyc(IDL - 60);
      expect_io(1'b1, 1'b0, "R6 still active inside window");
      cyc(80);
      expect_io(1'b0, 1'b1, "R6 inactivity drops link");

      // R5 low data restarts count
      send_req();
      pulses(10);
      pulse(1'b0);
      pulses(EDGES - 1);
      cyc(2);
      expect_io(1'b0, 1'b0, "R5 count restarted by low data");
      pulse(1'b1);
      cyc(2);
      expect_io(1'b1, 1'b0, "R5 enabled after fresh full run");
      cyc(IDL + 20);
      expect_io(1'b0, 1'b1, "R6 timeout after R5 run");

      // R10 and R6 timeout in the middle of the handshake
      send_req();
      pulses(10);
      cyc(IDL + 20);
      expect_io(1'b0, 1'b1, "R6 inactivity during handshake");
      send_req();
      pulses(EDGES - 1);
      cyc(2);
      expect_io(1'b0, 1'b0, "R10 earlier edges discarded");
      pulse(1'b1);
      cyc(2);
      expect_io(1'b1, 1'b0, "R10 enabled after full new run");
      cyc(IDL + 20);

      // R7 permanent disable
      perm_rst_off = 1'b1;
      cyc(2);
      expect_io(1'b0, 1'b0, "R7 idle with permanent disable");
      send_req();
      cyc(DL + 10);
      expect_io(1'b0, 1'b0, "R7 deadline expiry keeps reset function off");
      send_req();
      pulses(EDGES);
      cyc(2);
      expect_io(1'b1, 1'b0, "R7 activation with permanent disable");
      cyc(IDL + 20);
      expect_io(1'b0, 1'b0, "R7 inactivity keeps reset function off");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule